// File: doc/BRIEF.md
# Pointer-Addressed Register Bank Slave on a Two-Wire Serial Bus

This block lets a two-wire bus master (the common I2C protocol) read and write a bank of 8-bit registers. A fast system clock samples SCL and SDA. The block finds START, repeated START and STOP conditions and compares the 7-bit address against its own. It moves bytes most-significant bit first. It never drives a line high. To give an acknowledge it pulls SDA low, and for a NACK or a data bit of 1 it lets SDA float.

An internal register pointer selects the register. It is loaded from a command code, which must fall in a fixed legal range. There are three kinds of transfer:
- A write transfer that carries only a command code repositions the pointer.
- A write transfer with more bytes after the command stores them in consecutive registers.
- A read transfer returns registers starting at the pointer.

The pointer steps by one after each byte written or read, and wraps from the top legal code back to zero. While a reboot is flagged through `rebootBusy`, the block refuses its own address. The register storage sits outside the block and is reached through a one-cycle write strobe and a combinational read port.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins address reception from any state, and a STOP (SDA rises while SCL is high) returns the block to idle. Either condition releases SDA.
- R2: The address byte carries the slave address in bits 7:1 (default 0x3A) and the direction in bit 0 (0 = write, 1 = read). When the address matches, the block holds SDA low for the whole ninth clock.
- R3: The first byte of a write transfer is a command code. Codes 0x00 to 0x74 are acknowledged and loaded into the pointer. Any larger code gets a NACK, leaves the pointer unchanged, and causes later bytes of that transfer to be neither acknowledged nor written.
- R4: A write transfer that stops after the command code writes no register.
- R5: Each data byte after a legal command code is written to the register at the pointer and is acknowledged.
- R6: After each written byte the pointer advances by one, so successive bytes fill successive registers.
- R7: When the pointer advances from 0x74 it becomes 0x00. This applies to writes and to reads.
- R8: The pointer is 0x00 after reset. A STOP, or a START followed at once by a STOP, leaves it unchanged.
- R9: A read transfer returns the register at the pointer, MSB first, and the pointer advances by one after each byte sent.
- R10: After a read byte, a master ACK (SDA low) makes the block send the next register. A master NACK makes the block release SDA until the next START.
- R11: When the address does not match, SDA is never driven low and no register is written until the next START.
- R12: While `rebootBusy` is high, the block answers its own address with a NACK and writes nothing in that transfer.
- R13: A repeated START keeps the pointer, so a read that follows it starts at the register chosen before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 leaves it floating |
| rebootBusy | input | 1 | High while a reboot is in progress; own address is refused |
| regRdAddr | output | 7 | Register index for the read port (the pointer) |
| regRdData | input | 8 | Content of the register at `regRdAddr`, same cycle |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 7 | Register index for the write |
| regWrData | output | 8 | Byte to write |

## Verification
The bench builds the block with its defaults: slave address 0x3A, top legal code 0x74 and a two-stage synchronizer. The SCL period is twenty system clocks. With only 117 registers, random transfers often cross the wrap from 0x74 to 0x00, and about a quarter of the random command codes land in the illegal range 0x75 to 0xFF. Directed cases cover a wrong address, a refusal during reboot, a START followed at once by a STOP, and a repeated START before a read.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ADDR      = 3'd1,
    ST_CMD       = 3'd2,
    ST_WDATA     = 3'd3,
    ST_ACK       = 3'd4,
    ST_RDATA     = 3'd5,
    ST_RDATA_ACK = 3'd6,
    ST_IGNORE    = 3'd7
  } ctrlState_e;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaNow;
  } busEvents_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic wrReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic releaseSda;
  } dpStrobes_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
  import i2c_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output busEvents_t ev
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise = sclNow & ~sclPrev;
    ev.sclFall = ~sclNow & sclPrev;
    ev.startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaNow  = sdaNow;
  end

  // R1: bus conditions and SCL edges never coincide
  assert_events_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ev.sclRise, ev.sclFall, ev.startEv, ev.stopEv}));

endmodule

// File: rtl/i2c_slave_datapath.sv
module i2c_slave_datapath
  import i2c_reg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_REG = 116
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              sdaNow,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] rxNext,
  output logic              sdaLow,
  output logic [$clog2(MAX_REG+1)-1:0] ptr,
  output logic              regWrEn,
  output logic [$clog2(MAX_REG+1)-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData
);

  localparam int PTR_W = $clog2(MAX_REG + 1);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(MAX_REG);

  logic [DATA_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0]  ptrAdv;

  assign rxNext = {rxShift[DATA_W-2:0], sdaNow};
  assign ptrAdv = (ptr == PTR_TOP) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      ptr       <= '0;
      sdaLow    <= 1'b0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= rxNext;
      if (strb.loadPtr)     ptr <= rxNext[PTR_W-1:0];
      else if (strb.incPtr) ptr <= ptrAdv;
      regWrEn <= strb.wrReg;
      if (strb.wrReg) begin
        regWrAddr <= ptr;
        regWrData <= rxNext;
      end
      if (strb.loadTx)       txShift <= regRdData;
      else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.releaseSda)    sdaLow <= 1'b0;
      else if (strb.driveAck) sdaLow <= 1'b1;
      else if (strb.loadTx)   sdaLow <= ~regRdData[DATA_W-1];
      else if (strb.shiftTx)  sdaLow <= ~txShift[DATA_W-2];
    end
  end

  // R3: the pointer never leaves the legal code range
  assert_ptr_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_TOP);

  // R7: advancing from the top code lands on zero
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.loadPtr && ptr == PTR_TOP) |=> (ptr == '0));

  // R5: every write targets a legal register
  assert_wr_addr_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrAddr <= PTR_TOP));

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_reg_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         MAX_REG    = 116,
  parameter logic [6:0] SLAVE_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvents_t        ev,
  input  logic [DATA_W-1:0] rxNext,
  input  logic              sdaLowNow,
  input  logic              rebootBusy,
  output dpStrobes_t        strb
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] TOP_CODE = DATA_W'(MAX_REG);

  ctrlState_e stateQ, stateD, ackNextQ, ackNextD;
  logic [CNT_W-1:0] bitCntQ, bitCntD;
  logic ackHeldQ, ackHeldD, ackValQ, ackValD;
  logic byteDone, addrHit, cmdLegal;

  assign byteDone = (bitCntQ == LAST_BIT);
  assign addrHit  = (rxNext[DATA_W-1:1] == SLAVE_ADDR);
  assign cmdLegal = (rxNext <= TOP_CODE);

  always_comb begin
    strb     = '0;
    stateD   = stateQ;
    bitCntD  = bitCntQ;
    ackHeldD = ackHeldQ;
    ackValD  = ackValQ;
    ackNextD = ackNextQ;
    if (ev.startEv) begin
      stateD = ST_ADDR;
      bitCntD = '0;
      ackHeldD = 1'b0;
      strb.releaseSda = 1'b1;
    end else if (ev.stopEv) begin
      stateD = ST_IDLE;
      ackHeldD = 1'b0;
      strb.releaseSda = 1'b1;
    end else begin
      case (stateQ)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (ev.sclRise) begin
            strb.shiftIn = 1'b1;
            bitCntD = bitCntQ + 1'b1;
            if (byteDone) begin
              stateD = ST_ACK;
              ackHeldD = 1'b0;
              ackValD = 1'b1;
              case (stateQ)
                ST_ADDR: begin
                  if (!addrHit) stateD = ST_IGNORE;
                  else if (rebootBusy) begin
                    ackValD = 1'b0;
                    ackNextD = ST_IGNORE;
                  end else ackNextD = rxNext[0] ? ST_RDATA : ST_CMD;
                end
                ST_CMD: begin
                  if (cmdLegal) begin
                    strb.loadPtr = 1'b1;
                    ackNextD = ST_WDATA;
                  end else begin
                    ackValD = 1'b0;
                    ackNextD = ST_IGNORE;
                  end
                end
                default: begin
                  strb.wrReg = 1'b1;
                  strb.incPtr = 1'b1;
                  ackNextD = ST_WDATA;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            if (!ackHeldQ) begin
              ackHeldD = 1'b1;
              strb.driveAck = ackValQ;
            end else begin
              ackHeldD = 1'b0;
              bitCntD = '0;
              stateD = ackNextQ;
              if (ackNextQ == ST_RDATA) strb.loadTx = 1'b1;
              else strb.releaseSda = 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (ev.sclFall) strb.shiftTx = 1'b1;
          if (ev.sclRise) begin
            bitCntD = bitCntQ + 1'b1;
            if (byteDone) begin
              strb.incPtr = 1'b1;
              stateD = ST_RDATA_ACK;
              ackHeldD = 1'b0;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (ev.sclRise && ackHeldQ) ackValD = ~ev.sdaNow;
          if (ev.sclFall) begin
            if (!ackHeldQ) begin
              strb.releaseSda = 1'b1;
              ackHeldD = 1'b1;
            end else begin
              ackHeldD = 1'b0;
              bitCntD = '0;
              if (ackValQ) begin
                stateD = ST_RDATA;
                strb.loadTx = 1'b1;
              end else stateD = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      ackNextQ <= ST_IDLE;
      bitCntQ  <= '0;
      ackHeldQ <= 1'b0;
      ackValQ  <= 1'b0;
    end else begin
      stateQ   <= stateD;
      ackNextQ <= ackNextD;
      bitCntQ  <= bitCntD;
      ackHeldQ <= ackHeldD;
      ackValQ  <= ackValD;
    end
  end

  // R2: SDA is held low throughout a granted acknowledge clock
  assert_ack_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACK && ackHeldQ && ackValQ) |-> sdaLowNow);

  // R10: once a transfer is abandoned the line stays released
  assert_ignore_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IGNORE) |-> !sdaLowNow);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
  parameter int         MAX_REG     = 116,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(MAX_REG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic              rebootBusy,
  output logic [PTR_W-1:0]  regRdAddr,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [PTR_W-1:0]  regWrAddr,
  output logic [DATA_W-1:0] regWrData
);

  busEvents_t        ev;
  dpStrobes_t        strb;
  logic [DATA_W-1:0] rxNext;
  logic              sdaLow;
  logic [PTR_W-1:0]  ptr;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  i2c_slave_ctrl #(.DATA_W(DATA_W), .MAX_REG(MAX_REG), .SLAVE_ADDR(SLAVE_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .ev(ev), .rxNext(rxNext), .sdaLowNow(sdaLow),
    .rebootBusy(rebootBusy), .strb(strb)
  );

  i2c_slave_datapath #(.DATA_W(DATA_W), .MAX_REG(MAX_REG)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaNow(ev.sdaNow), .regRdData(regRdData),
    .rxNext(rxNext), .sdaLow(sdaLow), .ptr(ptr), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  assign sdaDriveLow = sdaLow;
  assign regRdAddr   = ptr;

endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
module i2c_regbank_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 5;
  localparam int WATCHDOG = 150000;
  localparam logic [6:0] OWN_ADDR = 7'h3A;
  localparam int TOP = 116;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic rebootBusy = 1'b0;
  logic sdaDriveLow, regWrEn;
  logic [6:0] regRdAddr, regWrAddr;
  logic [7:0] regRdData, regWrData;
  logic sdaBus;

  logic [7:0] bank [0:127];
  logic [7:0] expBank [0:127];
  int expPtr = 0;
  int vectors = 0, miscompares = 0;
  int wrCount = 0, lowCycles = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaBus = sdaM & ~sdaDriveLow;

  i2c_regbank_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow),
    .rebootBusy(rebootBusy), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  function automatic logic [7:0] initVal(int i);
    return 8'(i * 37 + 8'h5A);
  endfunction

  function automatic int advPtr(int p);
    return (p == TOP) ? 0 : p + 1;
  endfunction

  function automatic bit codeLegal(logic [7:0] c);
    return c <= 8'(TOP);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) bank[i] <= initVal(i);
    end else if (regWrEn) begin
      bank[regWrAddr] <= regWrData;
    end
  end
  assign regRdData = bank[regRdAddr];

  always @(negedge clk) begin
    cycles++;
    if (regWrEn) wrCount++;
    if (sdaDriveLow) lowCycles++;
    if (cycles > WATCHDOG && !finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b, output logic s1, output logic s2);
    sdaM = b;
    waitClk(QTR);
    sclM = 1'b1;
    waitClk(1);
    s1 = sdaBus;
    waitClk(2*QTR - 2);
    s2 = sdaBus;
    waitClk(1);
    sclM = 1'b0;
    waitClk(QTR);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(QTR);
    sclM = 1'b1; waitClk(2*QTR);
    sdaM = 1'b0; waitClk(2*QTR);
    sclM = 1'b0; waitClk(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(QTR);
    sclM = 1'b1; waitClk(2*QTR);
    sdaM = 1'b1; waitClk(2*QTR);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) clkBit(v[i], s1, s2);
    clkBit(1'b1, s1, s2);
    acked = (s1 == 1'b0) && (s2 == 1'b0);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] v);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s1, s2);
      v[i] = s2;
    end
    clkBit(giveAck ? 1'b0 : 1'b1, s1, s2);
  endtask

  task automatic txSetPtr(input logic [7:0] cmd);
    bit a;
    int w0 = wrCount;
    busStart();
    sendByte({OWN_ADDR, 1'b0}, a); check("R2 addr ack", a, 1);
    sendByte(cmd, a); check("R3 cmd ack", a, codeLegal(cmd));
    busStop();
    if (codeLegal(cmd)) expPtr = cmd;
    check("R4 send-byte writes nothing", wrCount - w0, 0);
  endtask

  task automatic txWrite(input logic [7:0] cmd, input int n);
    bit a;
    logic [7:0] d;
    int w0 = wrCount;
    busStart();
    sendByte({OWN_ADDR, 1'b0}, a); check("R2 addr ack", a, 1);
    sendByte(cmd, a); check("R3 cmd ack", a, codeLegal(cmd));
    if (codeLegal(cmd)) begin
      expPtr = cmd;
      for (int i = 0; i < n; i++) begin
        d = 8'($urandom);
        sendByte(d, a); check("R5 data ack", a, 1);
        expBank[expPtr] = d;
        expPtr = advPtr(expPtr);   // R6 / R7
      end
      busStop();
      check("R5 R6 write count", wrCount - w0, n);
    end else begin
      sendByte(8'($urandom), a); check("R3 data after bad code nacked", a, 0);
      busStop();
      check("R3 bad code writes nothing", wrCount - w0, 0);
    end
  endtask

  task automatic txRead(input int n);
    bit a;
    logic [7:0] v;
    busStart();
    sendByte({OWN_ADDR, 1'b1}, a); check("R2 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, v);
      check("R9 R10 read data", v, expBank[expPtr]);
      expPtr = advPtr(expPtr);
    end
    busStop();
  endtask

  function automatic logic [7:0] pickCode();
    int k = $urandom_range(0, 7);
    if (k < 2) return 8'($urandom_range(TOP + 1, 255));
    if (k == 2) return 8'($urandom_range(TOP - 3, TOP));
    return 8'($urandom_range(0, TOP));
  endfunction

  initial begin
    bit a;
    int w0, l0;
    logic [7:0] v;
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 128; i++) expBank[i] = initVal(i);
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);

    check("R8 reset sda released", sdaDriveLow, 0);
    check("R8 reset no write", regWrEn, 0);
    check("R8 reset pointer", regRdAddr, 0);

    // R9: read from the reset pointer
    txRead(2);

    // R8: START then STOP alone keeps the pointer
    txSetPtr(8'h10);
    busStart(); busStop();
    txRead(1);

    // R7: write and read across the wrap
    txWrite(8'h73, 3);
    txSetPtr(8'h73);
    txRead(3);

    // R3: illegal codes at the boundary
    txWrite(8'h75, 1);
    txSetPtr(8'hFF);
    txRead(1);

    // R11: foreign address stays silent
    w0 = wrCount; l0 = lowCycles;
    busStart();
    sendByte({OWN_ADDR ^ 7'h01, 1'b0}, a); check("R11 foreign addr nack", a, 0);
    sendByte(8'h05, a); check("R11 no ack later", a, 0);
    busStop();
    check("R11 SDA never driven", lowCycles - l0, 0);
    check("R11 no write", wrCount - w0, 0);
    txRead(1);

    // R12: reboot refuses own address
    rebootBusy = 1'b1;
    w0 = wrCount;
    busStart();
    sendByte({OWN_ADDR, 1'b0}, a); check("R12 reboot nack", a, 0);
    sendByte(8'h02, a); check("R12 cmd ignored", a, 0);
    sendByte(8'hAA, a);
    busStop();
    rebootBusy = 1'b0;
    check("R12 no write", wrCount - w0, 0);
    txRead(1);

    // R13: repeated START keeps the pointer
    txSetPtr(8'h30);
    busStart();
    sendByte({OWN_ADDR, 1'b0}, a); check("R13 write addr ack", a, 1);
    busStart();
    sendByte({OWN_ADDR, 1'b1}, a); check("R13 read addr ack", a, 1);
    recvByte(1'b0, v);
    check("R13 read after restart", v, expBank[expPtr]);
    expPtr = advPtr(expPtr);
    busStop();

    // R1 R10: idle after a NACKed read; a new transfer works
    check("R1 R10 released after stop", sdaDriveLow, 0);

    for (int t = 0; t < 40; t++) begin
      case ($urandom_range(0, 2))
        0: txSetPtr(pickCode());
        1: txWrite(pickCode(), $urandom_range(1, 4));
        default: txRead($urandom_range(1, 4));
      endcase
    end

    txSetPtr(8'h00);
    txRead(8);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule